// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns one active-low external interrupt pin into an interrupt request line for a CPU. The pin passes through a two-flop synchronizer. One of two sense modes then judges it. In level mode the request follows the synchronized pin while it is low. In edge mode a falling edge sets a pending latch. The latch holds until reset or until the CPU acknowledges the interrupt. An enable bit connects the pin to the request logic or cuts it off.

Software reaches the block through a small register bus: address, write enable, write data and a combinational read data path. The control register holds the sense-mode bit and the enable bit. A second register next to it is reserved and always reads zero. Outside special mode, the sense-mode bit can be written only once after reset, so a configuration made at boot cannot be changed by accident. The enable bit stays writable at all times.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the control register (offset 0x1E) reads 0x40, the reserved register (offset 0x1F) reads 0x00, and the request is low while the pin is high.
- R2: In the control register, bit 7 is the sense-mode bit (1 = falling edge, 0 = low level) and bit 6 is the enable bit. Bits 5..0 always read 0 and ignore written values.
- R3: The reserved register at offset 0x1F and every other unmapped address read 0x00. Writes to them change no readable state.
- R4: In level mode with the enable bit set, the request is high while the pin is low. It follows the pin two clock edges after the pin changes.
- R5: In edge mode, a synchronized pin sample of 1 followed by a sample of 0 sets a pending latch. The request stays high after the pin returns high. A pin held low does not set the latch again.
- R6: An acknowledge pulse clears the pending latch. If an acknowledge and a new falling edge fall in the same clock cycle, the latch stays set.
- R7: With the special-mode input high, the sense-mode bit can be rewritten any number of times.
- R8: With the special-mode input low, the first write to the control register after reset sets the sense-mode bit and locks it until reset. Later writes leave that bit unchanged but still update the enable bit.
- R9: With the enable bit at 0 the request is low. A pending edge survives disabling and drives the request again once the bit is set back to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| special_mode | input | 1 | High in special mode: the sense bit is always writable |
| irq_pin_n | input | 1 | Asynchronous active-low external interrupt pin |
| irq_ack | input | 1 | One-cycle service acknowledge; clears a pending edge |
| bus_addr | input | ADDR_W (8) | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_req | output | 1 | Interrupt request to the CPU, active high |

## Verification
A wrong lock flag shows at the ports on the next read of the control register. Bit 7 then either stays put after a write it should accept, or changes after a write it should refuse. A pending latch that clears or sets wrongly shows on the request line. It is seen one edge after the acknowledge or the synchronized edge, and it persists after the pin returns high, so a sample three edges after each pin change exposes it. A synchronizer whose reset value is wrong shows up as a false request right after reset.

// File: rtl/extirq_pkg.sv
// Package: shared field positions, reset value and config type for the
// external interrupt pin controller. Assumes an 8-bit register bus.
package extirq_pkg;
    localparam int DATA_W    = 8;
    localparam int SENSE_POS = 7;
    localparam int EN_POS    = 6;
    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h40;

    typedef struct packed {
        logic edge_mode;   // 1: falling edge, 0: low level
        logic pin_en;      // 1: pin connected to request logic
    } irq_cfg_t;
endpackage

// File: rtl/extirq_sync.sv
// Synchronizer: brings the asynchronous pin into the clock domain through
// STAGES flops. Assumes an idle-high pin, so the flops reset to 1 and no
// false edge follows reset.
module extirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flop chain; the last stage is the output.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_cfg.sv
// Register bank: control register (sense mode, enable) and a reserved
// register. The sense bit is write-once outside special mode; a single
// lock flag, cleared only by reset, enforces this. Read data is
// combinational on the address.
module extirq_cfg
    import extirq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1E,
    parameter logic [ADDR_W-1:0] RSV_ADDR  = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              special_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output irq_cfg_t          cfg_o
);
    irq_cfg_t cfg_q;
    logic     locked_q;
    logic     ctrl_wr;
    logic     sense_wr_ok;

    assign ctrl_wr     = we_i && (addr_i == CTRL_ADDR);
    assign sense_wr_ok = special_i || !locked_q;

    // Update the control fields; the sense bit only while writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.edge_mode <= CTRL_RESET[SENSE_POS];
            cfg_q.pin_en    <= CTRL_RESET[EN_POS];
        end else if (ctrl_wr) begin
            cfg_q.pin_en <= wdata_i[EN_POS];
            if (sense_wr_ok) cfg_q.edge_mode <= wdata_i[SENSE_POS];
        end
    end

    // Set the lock on the first control write outside special mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                       locked_q <= 1'b0;
        else if (ctrl_wr && !special_i)   locked_q <= 1'b1;
    end

    // Return the control fields at the control offset, zero elsewhere.
    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_ADDR) begin
            rdata_o[SENSE_POS] = cfg_q.edge_mode;
            rdata_o[EN_POS]    = cfg_q.pin_en;
        end
    end

    assign cfg_o = cfg_q;

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);

    // R8
    sense_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !special_i) |=> $stable(cfg_q.edge_mode));
endmodule

// File: rtl/extirq_sense.sv
// Sense logic: detects falling edges on the synchronized (active-low) pin,
// keeps them in a pending latch until acknowledged, and forms the request
// from either the latch or the pin level. Assumes the pin input is already
// synchronized. A same-cycle acknowledge loses to a new edge.
module extirq_sense
    import extirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_s_i,
    input  irq_cfg_t cfg_i,
    input  logic     ack_i,
    output logic     irq_o
);
    logic prev_q;
    logic pend_q;
    logic fall;
    logic new_edge;

    // Hold the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_s_i;
    end

    assign fall     = prev_q && !pin_s_i;
    assign new_edge = cfg_i.edge_mode && fall;

    // Set on a new edge, clear on acknowledge; a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (new_edge) pend_q <= 1'b1;
        else if (ack_i)    pend_q <= 1'b0;
    end

    // Pick the request source by sense mode, gated by the enable bit.
    always_comb begin
        if (!cfg_i.pin_en)        irq_o = 1'b0;
        else if (cfg_i.edge_mode) irq_o = pend_q;
        else                      irq_o = !pin_s_i;
    end

    // R5
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(cfg_i.edge_mode && prev_q && !pin_s_i));

    // R5
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.edge_mode && prev_q && !pin_s_i) |=> pend_q);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(cfg_i.edge_mode && prev_q && !pin_s_i)) |=> !pend_q);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack_i) |=> pend_q);
endmodule

// File: rtl/extirq_ctrl.sv
// Top: external interrupt pin controller. Synchronizes the pin, applies
// the configured sense mode and enable, and exposes the registers on a
// simple bus. Assumes ack is a one-cycle pulse from the interrupt service.
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1E,
    parameter logic [ADDR_W-1:0] RSV_ADDR  = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              special_mode,
    input  logic              irq_pin_n,
    input  logic              irq_ack,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req
);
    logic     pin_s;
    irq_cfg_t cfg;

    extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_pin_n),
        .sync_o  (pin_s)
    );

    extirq_cfg #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .RSV_ADDR  (RSV_ADDR)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .special_i (special_mode),
        .addr_i    (bus_addr),
        .we_i      (bus_we),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .cfg_o     (cfg)
    );

    extirq_sense u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s_i (pin_s),
        .cfg_i   (cfg),
        .ack_i   (irq_ack),
        .irq_o   (irq_req)
    );

    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == RSV_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic       irq_ack = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_req;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] CTRL = 8'h1E;
    localparam logic [7:0] RSV  = 8'h1F;

    always #5 clk = ~clk;

    extirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .irq_pin_n(irq_pin_n), .irq_ack(irq_ack), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_pin_n = 1'b1; irq_ack = 1'b0; bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // Drive the pin then wait until a latched edge is visible.
    task automatic pin_set(input logic v);
        @(negedge clk);
        irq_pin_n = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset values and an idle request
        rd_check("R1", CTRL, 8'h40);
        rd_check("R1", RSV, 8'h00);
        check("R1", {7'd0, irq_req}, 8'h00);

        // R3: sweep all addresses after reset
        for (int a = 0; a < 256; a++)
            rd_check("R3", a[7:0], (a[7:0] == CTRL) ? 8'h40 : 8'h00);

        // R2 R7: special mode, sweep every write value to control
        special_mode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            wr(CTRL, v[7:0]);
            rd_check("R2", CTRL, v[7:0] & 8'hC0);
        end
        // R3: reserved-register writes change nothing readable
        wr(CTRL, 8'h80);
        for (int v = 0; v < 256; v += 17) begin
            wr(RSV, v[7:0]);
            rd_check("R3", RSV, 8'h00);
            rd_check("R3", CTRL, 8'h80);
        end

        // R8: normal mode, every pair of (first, second) field values
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 4; s++) begin
                special_mode = 1'b0;
                do_reset();
                wr(CTRL, {f[1:0], 6'h3F});
                rd_check("R8", CTRL, {f[1:0], 6'h00});
                wr(CTRL, {s[1:0], 6'h00});
                rd_check("R8", CTRL, {f[1], s[0], 6'h00});
                wr(CTRL, {~f[1], s[0], 6'h00});
                rd_check("R8", CTRL, {f[1], s[0], 6'h00});
            end
        end
        // R7: special mode may change the sense bit even after a locking write
        do_reset();
        wr(CTRL, 8'h40);
        special_mode = 1'b1;
        wr(CTRL, 8'hC0);
        rd_check("R7", CTRL, 8'hC0);
        special_mode = 1'b0;

        // R4: level mode, check two edges after each pin change
        for (int en = 0; en < 2; en++) begin
            do_reset();
            special_mode = 1'b1;
            wr(CTRL, {1'b0, en[0], 6'h00});
            @(negedge clk); irq_pin_n = 1'b0;
            @(negedge clk);
            check("R4", {7'd0, irq_req}, 8'h00);
            @(negedge clk);
            check("R4", {7'd0, irq_req}, {7'd0, en[0]});
            irq_pin_n = 1'b1;
            repeat (2) @(negedge clk);
            check("R4", {7'd0, irq_req}, 8'h00);
        end

        // R5: edge mode latch survives pin release; held low does not relatch
        do_reset();
        wr(CTRL, 8'hC0);
        pin_set(1'b0);
        check("R5", {7'd0, irq_req}, 8'h01);
        ack_pulse();
        check("R6", {7'd0, irq_req}, 8'h00);
        repeat (4) @(negedge clk);
        check("R5", {7'd0, irq_req}, 8'h00);
        pin_set(1'b1);
        check("R5", {7'd0, irq_req}, 8'h00);
        pin_set(1'b0);
        pin_set(1'b1);
        check("R5", {7'd0, irq_req}, 8'h01);

        // R9: disable masks, pending survives, re-enable restores
        wr(CTRL, 8'h80);
        check("R9", {7'd0, irq_req}, 8'h00);
        rd_check("R9", CTRL, 8'h80);
        wr(CTRL, 8'hC0);
        check("R9", {7'd0, irq_req}, 8'h01);
        ack_pulse();
        check("R6", {7'd0, irq_req}, 8'h00);

        // R6: acknowledge in the same cycle as a new edge keeps the latch
        @(negedge clk); irq_pin_n = 1'b0;
        repeat (2) @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R6", {7'd0, irq_req}, 8'h01);
        ack_pulse();
        check("R6", {7'd0, irq_req}, 8'h00);
        pin_set(1'b1);

        // R9: edge while disabled is latched and shows after re-enable
        wr(CTRL, 8'h80);
        pin_set(1'b0);
        check("R9", {7'd0, irq_req}, 8'h00);
        pin_set(1'b1);
        wr(CTRL, 8'hC0);
        check("R9", {7'd0, irq_req}, 8'h01);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule